// File: doc/BRIEF.md
# Shift-Add Symmetric FIR Filter

This block is a linear-phase low-pass FIR filter built without multipliers. Every coefficient is a short bit vector. Each set bit adds a scaled copy of a delayed sample, so the datapath needs only shifts and adders. Samples are 8-bit signed two's complement and arrive one per clock at most, each qualified by a valid strobe. Every accepted sample produces one output that carries full precision.

The impulse response is mirror-symmetric. Tap k and tap NTAPS-1-k share one coefficient vector. The two samples at those taps are added first, and the shift-add network then runs on the folded pair, so only half of the vectors are stored and only half of the terms are built. The coefficient bit patterns are fixed when the design is compiled. The default build has 36 taps, 18 vectors of 8 bits, and a 22-bit output.

Top module: `sa_fir`

## Requirements
- R1: `din` is signed two's complement. Whenever `valid_in` is 1 at a rising edge, `din` enters the newest tap and every older sample moves one tap further back.
- R2: Coefficient vector k sits in `COEFS[k*CW +: CW]`. Bit m of that vector has weight 2^-m. The output is the real result scaled by 2^(CW-1), so it has CW-1 fractional bits. Bit m therefore contributes the sample times 2^(CW-1-m).
- R3: Taps k and NTAPS-1-k use the same vector k, for k < NTAPS/2. NTAPS must be even. After reset, the impulse x=1 followed by zeros produces the output sequence h(0), h(1) … h(NTAPS/2-1), h(NTAPS/2-1) … h(0) in integer scale.
- R4: `y_out` is the exact two's-complement sum, SUM_W = DW+1+CW+clog2(NTAPS/2) bits wide (22 by default), with no rounding, truncation or saturation. This holds for full-scale inputs of +127 and -128.
- R5: A sample accepted at edge E updates `y_out` at edge E+1, and `valid_out` is 1 for exactly the cycle after edge E+1. Back-to-back samples give back-to-back outputs. `valid_out` never rises without an accepted sample two edges earlier.
- R6: A cycle with `valid_in` at 0 leaves the delay line unchanged. `y_out` holds its last value whenever `valid_out` is 0.
- R7: Synchronous reset clears every tap, `y_out` and `valid_out` to 0 and drops any sample in flight. Outputs after reset treat all earlier history as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Qualifies `din` for this cycle |
| din | input | DW (8) | Signed input sample |
| valid_out | output | 1 | One-cycle pulse marking a new `y_out` |
| y_out | output | SUM_W (22) | Signed filter output with CW-1 fractional bits |

## Verification
A tap that shifts wrongly or a pairing that uses the wrong mirror index shows up in the impulse response within NTAPS outputs. There it appears as a missing, repeated or misplaced coefficient. A wrongly weighted bit or a dropped sign extension changes the very next output for full-scale steps or random samples, so every output is compared against an independent direct-form sum. A latency or hold fault shows on the first idle cycle. Reset is checked both at start-up and in the middle of a stream, with the output sequence after reset checked for zero history.

// File: rtl/sa_fir_pkg.sv
package sa_fir_pkg;

    // Default geometry of the filter
    localparam int SAMPLE_W  = 8;
    localparam int COEF_W    = 8;
    localparam int TAP_COUNT = 36;
    localparam int HALF_TAPS = TAP_COUNT / 2;

    // Vector k occupies bits [k*COEF_W +: COEF_W]; bit m weighs 2^-m
    localparam logic [HALF_TAPS*COEF_W-1:0] DEFAULT_COEFS =
        144'hE2_C4_A0_60_48_50_24_30_28_12_14_08_0A_06_00_04_02_01;

    // Width of the exact accumulated result
    function automatic int sum_width(input int dw, input int cw, input int taps);
        return dw + 1 + cw + $clog2(taps / 2);
    endfunction

    // Integer left shift that gives bit m its weight once the output is scaled by 2^(cw-1)
    function automatic int bit_shift(input int cw, input int m);
        return cw - 1 - m;
    endfunction

endpackage

// File: rtl/sa_fir_tap_line.sv
module sa_fir_tap_line #(
    parameter int DW = 8,
    parameter int N  = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  shift,
    input  logic [DW-1:0]         din,
    output logic [N-1:0][DW-1:0]  taps
);

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (shift) begin
            taps[0] <= din;
            for (int k = 1; k < N; k++) begin
                taps[k] <= taps[k-1];
            end
        end
    end

    AST_LINE_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        shift |=> (taps[0] == $past(din)) && (taps[1] == $past(taps[0]))) // R1
        else $error("line did not advance");

    AST_LINE_IDLE: assert property (@(posedge clk) disable iff (rst)
        !shift |=> $stable(taps)) // R6
        else $error("line moved while idle");

    AST_LINE_CLEAR: assert property (@(posedge clk)
        rst |=> (taps == '0)) // R7
        else $error("line not cleared");

endmodule

// File: rtl/sa_fir_fold.sv
module sa_fir_fold #(
    parameter int DW = 8,
    parameter int N  = 36
) (
    input  logic [N-1:0][DW-1:0]    taps,
    output logic [N/2-1:0][DW:0]    pairs
);

    localparam int HALF = N / 2;

    for (genvar k = 0; k < HALF; k++) begin : g_pair
        logic signed [DW:0] near_s;
        logic signed [DW:0] far_s;
        assign near_s   = {taps[k][DW-1], taps[k]};
        assign far_s    = {taps[N-1-k][DW-1], taps[N-1-k]};
        assign pairs[k] = near_s + far_s;
    end

endmodule

// File: rtl/sa_fir_term.sv
module sa_fir_term
    import sa_fir_pkg::*;
#(
    parameter int            PW  = 9,
    parameter int            CW  = 8,
    parameter logic [CW-1:0] VEC = '0
) (
    input  logic [PW-1:0]    pair,
    output logic [PW+CW-1:0] term
);

    localparam int TW = PW + CW;

    logic signed [TW-1:0] ext;
    logic signed [TW-1:0] acc;

    assign ext = {{CW{pair[PW-1]}}, pair};

    always_comb begin
        acc = '0;
        for (int m = 0; m < CW; m++) begin
            if (VEC[m]) begin
                acc = acc + (ext <<< bit_shift(CW, m));
            end
        end
    end

    assign term = acc;

endmodule

// File: rtl/sa_fir.sv
module sa_fir
    import sa_fir_pkg::*;
#(
    parameter int                               DW    = SAMPLE_W,
    parameter int                               CW    = COEF_W,
    parameter int                               NTAPS = TAP_COUNT,
    parameter logic [(NTAPS/2)*CW-1:0]          COEFS = DEFAULT_COEFS,
    localparam int                              SUM_W = sum_width(DW, CW, NTAPS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_in,
    input  logic [DW-1:0]     din,
    output logic              valid_out,
    output logic [SUM_W-1:0]  y_out
);

    localparam int HALF = NTAPS / 2;
    localparam int PW   = DW + 1;
    localparam int TW   = PW + CW;

    logic [NTAPS-1:0][DW-1:0] taps;
    logic [HALF-1:0][PW-1:0]  pairs;
    logic [HALF-1:0][TW-1:0]  terms;
    logic signed [SUM_W-1:0]  total;
    logic                     valid_q;

    sa_fir_tap_line #(.DW(DW), .N(NTAPS)) i_line (
        .clk   (clk),
        .rst   (rst),
        .shift (valid_in),
        .din   (din),
        .taps  (taps)
    );

    sa_fir_fold #(.DW(DW), .N(NTAPS)) i_fold (
        .taps  (taps),
        .pairs (pairs)
    );

    for (genvar k = 0; k < HALF; k++) begin : g_term
        sa_fir_term #(
            .PW  (PW),
            .CW  (CW),
            .VEC (COEFS[k*CW +: CW])
        ) i_term (
            .pair (pairs[k]),
            .term (terms[k])
        );
    end

    always_comb begin
        total = '0;
        for (int k = 0; k < HALF; k++) begin
            total = total + {{(SUM_W-TW){terms[k][TW-1]}}, terms[k]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q   <= 1'b0;
            valid_out <= 1'b0;
            y_out     <= '0;
        end else begin
            valid_q   <= valid_in;
            valid_out <= valid_q;
            if (valid_q) begin
                y_out <= total;
            end
        end
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> ##1 valid_out) // R5
        else $error("output pulse missing");

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !valid_in |=> ##1 !valid_out) // R5
        else $error("output pulse without sample");

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_q |=> $stable(y_out)) // R6
        else $error("output changed without new sample");

    AST_OUT_CLEAR: assert property (@(posedge clk)
        rst |=> (!valid_out && (y_out == '0))) // R7
        else $error("output not cleared");

endmodule

// File: tb/test_sa_fir.sv
module test_sa_fir;
    import sa_fir_pkg::*;

    localparam int DW    = SAMPLE_W;
    localparam int CW    = COEF_W;
    localparam int NT    = TAP_COUNT;
    localparam int HT    = NT / 2;
    localparam int SW    = sum_width(DW, CW, NT);

    // Stimulus table: {valid, sample}
    localparam logic [DW:0] TABLE [0:19] = '{
        9'h105, 9'h1FB, 9'h07F, 9'h17F, 9'h180, 9'h000, 9'h000, 9'h110,
        9'h1F0, 9'h133, 9'h0AA, 9'h1CD, 9'h101, 9'h1FF, 9'h000, 9'h164,
        9'h19C, 9'h100, 9'h07F, 9'h142
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic [DW-1:0] din = '0;
    logic          valid_out;
    logic [SW-1:0] y_out;

    int     checks = 0;
    int     failures = 0;
    bit     done = 1'b0;
    longint hist [NT];
    longint d1_y = 0, d2_y = 0, last_y = 0;
    bit     d1_v = 0, d2_v = 0;

    always #4 clk = ~clk;

    sa_fir i_sa_fir (
        .clk(clk), .rst(rst), .valid_in(valid_in), .din(din),
        .valid_out(valid_out), .y_out(y_out)
    );

    function automatic longint coef_int(input int k);
        int kk;
        logic [CW-1:0] v;
        longint s;
        kk = (k < HT) ? k : NT - 1 - k;
        v  = DEFAULT_COEFS[kk*CW +: CW];
        s  = 0;
        for (int m = 0; m < CW; m++) begin
            if (v[m]) s += longint'(1) << (CW - 1 - m);
        end
        return s;
    endfunction

    function automatic longint model_out();
        longint s = 0;
        for (int k = 0; k < NT; k++) s += coef_int(k) * hist[k];
        return s;
    endfunction

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit v, input logic [DW-1:0] x, input string tag);
        longint ya;
        @(negedge clk);
        ya = longint'($signed(y_out));
        check(valid_out === d2_v, "R5 valid_out timing", longint'(valid_out), longint'(d2_v));
        if (d2_v) check(ya == d2_y, tag, ya, d2_y);
        else      check(ya == last_y, "R6 hold while idle", ya, last_y);
        last_y = ya;
        valid_in = v;
        din = x;
        d2_v = d1_v;
        d2_y = d1_y;
        d1_v = v;
        if (v) begin
            for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
            hist[0] = longint'($signed(x));
            d1_y = model_out();
        end
    endtask

    task automatic do_reset();
        longint ya;
        @(negedge clk);
        rst = 1'b1;
        valid_in = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        ya = longint'($signed(y_out));
        check(ya == 0, "R7 reset output", ya, 0);
        check(valid_out == 1'b0, "R7 reset valid_out", longint'(valid_out), 0);
        for (int k = 0; k < NT; k++) hist[k] = 0;
        d1_v = 0; d2_v = 0; d1_y = 0; d2_y = 0; last_y = 0;
    endtask

    initial begin
        for (int k = 0; k < NT; k++) hist[k] = 0;
        do_reset();

        // R1: table walk with idle gaps
        for (int i = 0; i < 20; i++) step(TABLE[i][DW], TABLE[i][DW-1:0], "R1 table output");
        step(0, '0, "R6 drain");
        step(0, '0, "R6 drain");

        // R2 R3: impulse reproduces coefficients in mirror order
        do_reset();
        step(1, 8'd1, "R2 R3 impulse");
        for (int i = 0; i < NT + 2; i++) step(1, 8'd0, "R2 R3 impulse");

        // R4: full-scale steps
        for (int i = 0; i < NT + 4; i++) step(1, 8'h7F, "R4 positive step");
        for (int i = 0; i < NT + 4; i++) step(1, 8'h80, "R4 negative step");
        for (int i = 0; i < 20; i++) step(1, (i % 2) ? 8'h80 : 8'h7F, "R4 alternating");

        // R4 R5: random samples with random gaps
        for (int i = 0; i < 300; i++) step(($urandom % 4) != 0, 8'($urandom), "R4 random");
        step(0, '0, "R6 drain");
        step(0, '0, "R6 drain");

        // R7: reset in mid-stream, then impulse with zero history
        for (int i = 0; i < 5; i++) step(1, 8'h55, "R4 prefill");
        do_reset();
        step(1, 8'hFF, "R7 post-reset impulse");
        for (int i = 0; i < NT + 2; i++) step(1, 8'd0, "R7 post-reset impulse");
        repeat (4) step(0, '0, "R6 idle hold");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule